// File: doc/BRIEF.md
# Ethernet Receive Pad Stripper

This block sits in an Ethernet receive path, after the start-of-frame delimiter. It accepts one byte per handshake. The first accepted byte is the first destination-address byte and the last one is the final FCS byte. Bytes 12 and 13 hold the 802.3 length/type value. When trimming is enabled and that value is below the minimum data size, the block passes on only the header and the declared number of data bytes. The pad and the four FCS bytes are discarded. Every other frame goes through byte for byte.

A CRC-32 checker watches every accepted byte, whether or not it is forwarded, including pad and FCS. After the last input byte it raises a one-cycle status strobe. The strobe carries an FCS error flag and the number of bytes forwarded for that frame. The forwarded stream leaves through a one-deep valid/ready register. Back-pressure from the host side holds the input only when the next byte would be forwarded. Bytes being discarded keep flowing in.

Top module: `rx_pad_trim`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid` and `sts_valid` are 0 and `in_ready` is 1.
- R2: With trimming in effect for a frame, the length value L is taken from byte 12 (most significant) and byte 13 (least significant), counting from 0 at the `in_sof` byte. If L < 46, the output is exactly the first 14+L bytes, in order. `out_eof` marks byte 13+L, and pad and FCS bytes never appear.
- R3: With trimming in effect, a length/type value of 46 or more, type codes such as 0x0800 included, passes the whole frame unchanged, FCS included.
- R4: With trimming off, every input byte, pad and FCS included, is forwarded unchanged, and `out_eof` marks the byte that carried `in_eof`.
- R5: The CRC uses the reflected polynomial 0xEDB88320 and starts from all ones at `in_sof`. It runs over every accepted byte including pad and FCS. `sts_crc_err` is 1 exactly when the remainder after the `in_eof` byte differs from 0xDEBB20E3, and a trimmed frame is checked the same way.
- R6: `sts_count` equals the number of bytes forwarded for the frame, which is 14+L for a trimmed frame.
- R7: `sts_valid` is high for one cycle, the cycle after the `in_eof` byte is accepted.
- R8: While `out_valid` is high and `out_ready` low, `out_data`, `out_sof` and `out_eof` hold. In that state `in_ready` is 0 for a byte that would be forwarded. No byte is lost, repeated or reordered.
- R9: `strip_en` is sampled on the `in_sof` byte, and changes later in the frame have no effect on that frame.
- R10: `out_sof` marks exactly the first forwarded byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | Trimming enable, sampled at frame start |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of frame (first destination byte) |
| in_eof | input | 1 | Last byte of frame (last FCS byte) |
| out_valid | output | 1 | Forwarded byte present |
| out_ready | input | 1 | Host side accepts forwarded byte |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of frame |
| out_eof | output | 1 | Last forwarded byte of frame |
| sts_valid | output | 1 | Frame status strobe |
| sts_crc_err | output | 1 | FCS mismatch for the frame |
| sts_count | output | CNT_W | Bytes forwarded for the frame |

## Verification
The bench builds the block with its defaults: CNT_W = 11, a 14-byte header and a minimum data size of 46. These settings reach the full 1500-byte payload, whose 1518-byte count fits the counter, and the 45/46 trim boundary. Vector frames cover length values 0, 1, 45 and 46, a type code, trimming off, corrupted FCS on trimmed and untrimmed frames, and `strip_en` flipping mid-frame. Two vectors run with random output back-pressure, and a directed stall checks that the output register holds and that `in_ready` drops.

// File: rtl/rx_pad_trim_pkg.sv
package rx_pad_trim_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
        logic       eof;
    } beat_t;

    // One byte of the reflected CRC, least significant bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_pad_trim_crc.sv
module rx_pad_trim_crc
    import rx_pad_trim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       first,
    input  logic [7:0] data,
    output logic       mismatch
);

    typedef struct packed {
        logic [31:0] crc;
    } crc_state_t;

    crc_state_t s_d, s_q;
    logic [31:0] crc_after;

    always_comb begin
        s_d       = s_q;
        crc_after = crc_byte(first ? CRC_SEED : s_q.crc, data);
        if (take) begin
            s_d.crc = crc_after;
        end
        mismatch = (crc_after != CRC_RESIDUE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.crc <= CRC_SEED;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rx_pad_trim_track.sv
module rx_pad_trim_track #(
    parameter int CNT_W     = 11,
    parameter int HDR_BYTES = 14,
    parameter int MIN_DATA  = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             sof,
    input  logic             eof,
    input  logic [7:0]       data,
    input  logic             strip_en,
    output logic             keep,
    output logic             last_kept,
    output logic [CNT_W-1:0] kept_total
);

    localparam logic [CNT_W-1:0] LEN_HI_IDX = CNT_W'(HDR_BYTES - 2);
    localparam logic [CNT_W-1:0] LEN_LO_IDX = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] IDX_MAX    = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] fwd;
        logic [7:0]       len_hi;
        logic             trim;
        logic             en;
    } trk_state_t;

    trk_state_t s_d, s_q;

    logic [CNT_W-1:0] idx;
    logic             en_cur;
    logic [15:0]      len_val;
    logic             trim_now;
    logic [CNT_W-1:0] limit_now;
    logic             at_lo;
    logic             trim_eff;
    logic [CNT_W-1:0] limit_eff;

    always_comb begin
        idx       = sof ? '0 : s_q.idx;
        en_cur    = sof ? strip_en : s_q.en;
        len_val   = {s_q.len_hi, data};
        trim_now  = en_cur && (len_val < 16'(MIN_DATA));
        limit_now = CNT_W'(HDR_BYTES) + CNT_W'(len_val);
        at_lo     = (idx == LEN_LO_IDX);
        trim_eff  = at_lo ? trim_now : (s_q.trim && (idx > LEN_LO_IDX));
        limit_eff = at_lo ? limit_now : s_q.limit;

        keep       = !trim_eff || (idx < limit_eff);
        last_kept  = keep && (eof || (trim_eff && ((idx + ONE) == limit_eff)));
        kept_total = (sof ? '0 : s_q.fwd) + {{(CNT_W-1){1'b0}}, keep};

        s_d = s_q;
        if (take) begin
            s_d.idx = (idx == IDX_MAX) ? idx : idx + ONE;
            s_d.en  = en_cur;
            s_d.fwd = kept_total;
            if (sof) begin
                s_d.trim = 1'b0;
            end
            if (idx == LEN_HI_IDX) begin
                s_d.len_hi = data;
            end
            if (at_lo) begin
                s_d.trim  = trim_now;
                s_d.limit = limit_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rx_pad_trim_outreg.sv
module rx_pad_trim_outreg
    import rx_pad_trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  beat_t in_beat,
    input  logic  out_ready,
    output logic  slot_free,
    output logic  out_valid,
    output beat_t out_beat
);

    typedef struct packed {
        logic  valid;
        beat_t beat;
    } out_state_t;

    out_state_t s_d, s_q;

    always_comb begin
        slot_free = !s_q.valid || out_ready;
        s_d       = s_q;
        if (slot_free) begin
            s_d.valid = push;
            if (push) begin
                s_d.beat = in_beat;
            end
        end
        out_valid = s_q.valid;
        out_beat  = s_q.beat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rx_pad_trim.sv
module rx_pad_trim
    import rx_pad_trim_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int HDR_BYTES = 14,
    parameter int MIN_DATA  = 46
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             sts_valid,
    output logic             sts_crc_err,
    output logic [CNT_W-1:0] sts_count
);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [CNT_W-1:0] count;
    } sts_state_t;

    sts_state_t s_d, s_q;

    logic             take;
    logic             keep;
    logic             last_kept;
    logic [CNT_W-1:0] kept_total;
    logic             slot_free;
    logic             crc_bad;
    beat_t            in_beat;
    beat_t            out_beat;

    rx_pad_trim_track #(
        .CNT_W    (CNT_W),
        .HDR_BYTES(HDR_BYTES),
        .MIN_DATA (MIN_DATA)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .sof       (in_sof),
        .eof       (in_eof),
        .data      (in_data),
        .strip_en  (strip_en),
        .keep      (keep),
        .last_kept (last_kept),
        .kept_total(kept_total)
    );

    rx_pad_trim_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (in_sof),
        .data    (in_data),
        .mismatch(crc_bad)
    );

    rx_pad_trim_outreg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take && keep),
        .in_beat  (in_beat),
        .out_ready(out_ready),
        .slot_free(slot_free),
        .out_valid(out_valid),
        .out_beat (out_beat)
    );

    always_comb begin
        in_ready     = !keep || slot_free;
        take         = in_valid && in_ready;
        in_beat.data = in_data;
        in_beat.sof  = in_sof;
        in_beat.eof  = last_kept;

        s_d       = s_q;
        s_d.valid = take && in_eof;
        if (take && in_eof) begin
            s_d.err   = crc_bad;
            s_d.count = kept_total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data    = out_beat.data;
    assign out_sof     = out_beat.sof;
    assign out_eof     = out_beat.eof;
    assign sts_valid   = s_q.valid;
    assign sts_crc_err = s_q.err;
    assign sts_count   = s_q.count;

endmodule

// File: rtl/rx_pad_trim_checks.sv
module rx_pad_trim_checks #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eof,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             sts_valid,
    input logic             sts_crc_err,
    input logic [CNT_W-1:0] sts_count
);

    // R8: a stalled output byte stays put
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eof)));

    // R8: a new output byte always comes from an accepted input byte
    a_r8_rise_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R7: status follows acceptance of the last input byte
    a_r7_sts_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> $past(in_valid && in_ready && in_eof));

    // R5: status fields are defined whenever reported
    a_r5_sts_known: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> !$isunknown({sts_crc_err, sts_count}));

endmodule

bind rx_pad_trim rx_pad_trim_checks #(.CNT_W(CNT_W)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_eof     (in_eof),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .sts_valid  (sts_valid),
    .sts_crc_err(sts_crc_err),
    .sts_count  (sts_count)
);

// File: tb/rx_pad_trim_bench.sv
`timescale 1ns/1ps
module rx_pad_trim_bench;

    localparam int CNT_W = 11;
    localparam int MAXB  = 1600;
    localparam int NVEC  = 13;

    // {flip[30], stall[29], bad_fcs[28], strip[27], body_len[26:16], len_type[15:0]}
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 11'd46,   16'd0},
        {1'b0, 1'b0, 1'b0, 1'b1, 11'd46,   16'd1},
        {1'b0, 1'b0, 1'b0, 1'b1, 11'd46,   16'd45},
        {1'b0, 1'b0, 1'b0, 1'b1, 11'd46,   16'd46},
        {1'b0, 1'b0, 1'b0, 1'b1, 11'd60,   16'h0800},
        {1'b0, 1'b0, 1'b0, 1'b0, 11'd46,   16'd10},
        {1'b0, 1'b0, 1'b1, 1'b1, 11'd46,   16'd20},
        {1'b0, 1'b0, 1'b1, 1'b1, 11'd100,  16'd100},
        {1'b0, 1'b1, 1'b0, 1'b1, 11'd46,   16'd5},
        {1'b0, 1'b1, 1'b0, 1'b0, 11'd64,   16'd64},
        {1'b1, 1'b0, 1'b0, 1'b1, 11'd46,   16'd3},
        {1'b1, 1'b0, 1'b0, 1'b0, 11'd46,   16'd3},
        {1'b0, 1'b0, 1'b0, 1'b0, 11'd1500, 16'd1500}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n, strip_en, in_valid, in_ready, in_sof, in_eof;
    logic             out_valid, out_ready, out_sof, out_eof;
    logic             sts_valid, sts_crc_err;
    logic [7:0]       in_data, out_data;
    logic [CNT_W-1:0] sts_count;

    rx_pad_trim #(.CNT_W(CNT_W)) u_rx_pad_trim (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rmode  = 0;
    logic [7:0] lfsr = 8'h5A;

    logic [7:0] frm [MAXB];
    logic [7:0] got [MAXB];
    int frm_n, got_n, sof_cnt, eof_cnt, sof_pos, eof_pos, sts_seen, sts_cyc, eof_cyc;
    logic sts_err_got;
    logic [CNT_W-1:0] sts_cnt_got;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (got_n < MAXB) got[got_n] = out_data;
                if (out_sof) begin sof_cnt++; sof_pos = got_n; end
                if (out_eof) begin eof_cnt++; eof_pos = got_n; end
                got_n++;
            end
            if (sts_valid) begin
                sts_seen++;
                sts_cyc     = cyc;
                sts_err_got = sts_crc_err;
                sts_cnt_got = sts_count;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (actual=running expected=done)");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[2] : 1'b0;
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb = r[0] ^ d[b];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    task automatic build_frame(input int lenval, input int body_n, input bit bad);
        logic [31:0] c;
        frm_n = 0;
        for (int i = 0; i < 6; i++) begin frm[frm_n] = 8'(8'h10 + i); frm_n++; end
        for (int i = 0; i < 6; i++) begin frm[frm_n] = 8'(8'h60 + i); frm_n++; end
        frm[frm_n] = 8'(lenval >> 8); frm_n++;
        frm[frm_n] = 8'(lenval);      frm_n++;
        for (int i = 0; i < body_n; i++) begin
            frm[frm_n] = (i < lenval) ? 8'(i * 7 + 3) : 8'h00;
            frm_n++;
        end
        c = 32'hFFFFFFFF;
        for (int j = 0; j < frm_n; j++) c = ref_crc(c, frm[j]);
        c = ~c;
        if (bad) c = c ^ 32'h1;
        for (int k = 0; k < 4; k++) begin frm[frm_n] = 8'(c >> (8 * k)); frm_n++; end
    endtask

    task automatic send_frame(input bit strip, input bit flip);
        bit acc;
        got_n = 0; sof_cnt = 0; eof_cnt = 0; sof_pos = -1; eof_pos = -1;
        sts_seen = 0; sts_cyc = -1; eof_cyc = -1;
        for (int i = 0; i < frm_n; i++) begin
            in_valid = 1'b1;
            in_data  = frm[i];
            in_sof   = (i == 0);
            in_eof   = (i == frm_n - 1);
            strip_en = (i == 0 || !flip) ? strip : !strip;
            do begin
                @(negedge clk);
                acc = in_ready;
                if (acc && in_eof) eof_cyc = cyc;
                tick();
            end while (!acc);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        for (int k = 0; k < 4000 && !(sts_seen > 0 && eof_cnt > 0); k++) tick();
        tick();
        tick();
    endtask

    task automatic run_vector(input logic [30:0] v);
        int lenval = int'(v[15:0]);
        int body_n = int'(v[26:16]);
        bit strip  = v[27];
        bit bad    = v[28];
        bit stall  = v[29];
        bit flip   = v[30];
        bit trim   = strip && (lenval < 46);
        int exp_n;
        int mism = -1;
        string req;
        req = flip ? "R9" : stall ? "R8" : trim ? "R2" : strip ? "R3" : "R4";
        rmode = stall ? 1 : 0;
        build_frame(lenval, body_n, bad);
        send_frame(strip, flip);
        rmode = 0;
        exp_n = trim ? 14 + lenval : frm_n;
        chk(got_n == exp_n, req, "forwarded byte count", got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n; i++) begin
            if (mism < 0 && got[i] !== frm[i]) mism = i;
        end
        chk(mism < 0, req, "first mismatching byte index", mism, -1);
        chk(eof_cnt == 1 && eof_pos == exp_n - 1, req, "out_eof position", eof_pos, exp_n - 1);
        chk(sof_cnt == 1 && sof_pos == 0, "R10", "out_sof position", sof_pos, 0);
        chk(sts_seen == 1 && sts_err_got == bad, "R5", "crc error flag", sts_err_got, bad);
        chk(int'(sts_cnt_got) == exp_n, "R6", "status byte count", sts_cnt_got, exp_n);
        chk(sts_cyc == eof_cyc + 1, "R7", "status cycle after eof accept", sts_cyc, eof_cyc + 1);
    endtask

    initial begin
        rst_n = 1'b0; strip_en = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        in_data = 8'h00; out_ready = 1'b1;
        got_n = 0; sof_cnt = 0; eof_cnt = 0; sts_seen = 0;
        repeat (4) tick();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(sts_valid == 1'b0, "R1", "sts_valid in reset", sts_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && sts_valid == 1'b0, "R1", "outputs idle after reset",
            {out_valid, sts_valid}, 0);
        tick();

        for (int n = 0; n < NVEC; n++) run_vector(VEC[n]);

        // Directed stall: output register full, host not ready
        rmode = 2;
        tick();
        in_valid = 1'b1; in_data = 8'hC3; in_sof = 1'b1; in_eof = 1'b0; strip_en = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8", "in_ready with empty slot", in_ready, 1);
        tick();
        in_data = 8'h11; in_sof = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'hC3, "R8", "stalled byte present", out_data, 8'hC3);
        chk(in_ready == 1'b0, "R8", "in_ready low while stalled", in_ready, 0);
        repeat (3) tick();
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'hC3 && out_sof == 1'b1, "R8",
            "stalled byte held", out_data, 8'hC3);
        in_valid = 1'b0;
        rst_n = 1'b0;
        rmode = 0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();

        summary();
        $finish;
    end

endmodule